// File: doc/BRIEF.md
# Indexed Block-Access Serial Register Slave

This block is a two-wire serial bus slave in the SMBus/I2C style. It gives a host read and write access to a small bank of byte-wide configuration registers. A system clock oversamples both bus lines through a synchroniser. From the sampled lines the block detects START, repeated START and STOP conditions and shifts bytes in and out. It drives the data line only as an open-drain pull-down, through `sdaOe`, for acknowledges and read data. The rest of the chip sees the whole register bank at once on a flat parallel output.

Every access names a starting register index. A write then gives a byte count, followed by that many data bytes, which land in consecutive registers. A read first sends a write-addressed frame that carries only the index. After a repeated START and the read address, the slave returns a length byte and then consecutive register contents. The length byte is taken from a dedicated register, so the host sets how many bytes each read returns. The host acknowledges each byte and ends the read with a not-acknowledge and STOP.

Top module: `smb_block_regs`

## Requirements
- R1: After reset, every register reads 0x00 except the length register at index 8, which reads 0x08, and `sdaOe` is 0 (data line released).
- R2: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). After any other address byte it sends no acknowledge, and it acknowledges and writes nothing until the next START.
- R3: A write frame is: address 0xD2, index N, count X, then X data bytes. The slave acknowledges each of these bytes and stores the data bytes in registers N through N+X-1. Register contents change only while data bytes are being written.
- R4: A read frame is: address 0xD2, index N, repeated START, address 0xD3. The slave then sends the length byte, followed by registers N, N+1, and so on, each byte MSB first.
- R5: The length byte sent on a read equals the current contents of register 8, which the host can write like any other register.
- R6: A data byte written to an index at or beyond the number of registers is acknowledged but discarded. A read from such an index returns 0x00.
- R7: Data bytes sent after the X bytes announced by the count are not acknowledged and are not stored.
- R8: A START or STOP detected in the middle of a byte aborts the transfer. Registers written earlier keep their values, and the next transfer works normally.
- R9: The slave changes its drive of the data line only while the clock line is low.
- R10: When the host does not acknowledge a byte sent by the slave, the slave releases the data line and sends no further bytes until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |
| regsOut | output | NUM_REGS*8 | Register bank; register i occupies bits [8*i+7:8*i] |

## Verification
A wrong phase or bit count in the control state shows up at the bus within one byte. An acknowledge appears where none should, or is missing, and the scoreboard compares every acknowledge slot against expectations. A wrong index or remaining-count value shows as a wrong length or data byte on read-back, or as a register change in the wrong place on `regsOut`, at the latest by the end of the next transfer. Abort and not-acknowledge cases are followed by a fresh transfer or an extra clocked byte. A state that failed to return to idle, or kept driving the line, is therefore exposed within the next nine bus clocks.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RCOUNT,
    PH_RDATA,
    PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic loadIndex;
    logic loadRemain;
    logic writeReg;
    logic loadCount;
    logic loadNext;
    logic txBit;
    logic setOe;
    logic clrOe;
  } strobe_t;
endpackage

// File: rtl/smb_line_sense.sv
module smb_line_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclQ,
  output logic sdaQ,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  assign sclQ      = sclSync[SYNC_STAGES-1];
  assign sdaQ      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = !sclPrev && sclQ;
  assign sclFall   = sclPrev && !sclQ;
  // data edges while the clock line stays high mark bus conditions
  assign startSeen = sclPrev && sclQ && sdaPrev && !sdaQ;
  assign stopSeen  = sclPrev && sclQ && !sdaPrev && sdaQ;
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl import smb_regs_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclRise,
  input  logic                 sclFall,
  input  logic                 startSeen,
  input  logic                 stopSeen,
  input  logic                 sdaQ,
  input  logic [BYTE_W-1:0]    rxByte,
  input  logic                 remainZero,
  output strobe_t              st,
  output phase_t               phase,
  output logic [BIT_CNT_W-1:0] bitCnt
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_W);

  phase_t phaseN, pend, pendN;
  logic [BIT_CNT_W-1:0] bitN;
  logic ackThis, ackN;
  logic rxPhase, txPhase;

  assign rxPhase = (phase == PH_ADDR) || (phase == PH_INDEX) ||
                   (phase == PH_COUNT) || (phase == PH_WDATA);
  assign txPhase = (phase == PH_RCOUNT) || (phase == PH_RDATA);

  always_comb begin
    st     = '0;
    phaseN = phase;
    bitN   = bitCnt;
    ackN   = ackThis;
    pendN  = pend;
    if (startSeen) begin
      phaseN   = PH_ADDR;
      bitN     = '0;
      ackN     = 1'b0;
      st.clrOe = 1'b1;
    end else if (stopSeen) begin
      phaseN   = PH_IDLE;
      bitN     = '0;
      ackN     = 1'b0;
      st.clrOe = 1'b1;
    end else if (phase != PH_IDLE && phase != PH_IGNORE) begin
      if (sclRise) begin
        if (bitCnt != ACK_SLOT) begin
          st.shiftIn = 1'b1;
          bitN = bitCnt + 1'b1;
          if (bitCnt == LAST_BIT && rxPhase) begin
            unique case (phase)
              PH_ADDR: begin
                if (rxByte == {DEV_ADDR, 1'b0}) begin
                  ackN = 1'b1; pendN = PH_INDEX;
                end else if (rxByte == {DEV_ADDR, 1'b1}) begin
                  ackN = 1'b1; pendN = PH_RCOUNT;
                end else begin
                  ackN = 1'b0; pendN = PH_IGNORE;
                end
              end
              PH_INDEX: begin
                st.loadIndex = 1'b1; ackN = 1'b1; pendN = PH_COUNT;
              end
              PH_COUNT: begin
                st.loadRemain = 1'b1; ackN = 1'b1; pendN = PH_WDATA;
              end
              default: begin
                if (!remainZero) begin
                  st.writeReg = 1'b1; ackN = 1'b1; pendN = PH_WDATA;
                end else begin
                  ackN = 1'b0; pendN = PH_IGNORE;
                end
              end
            endcase
          end
        end else begin
          bitN = '0;
          if (rxPhase) begin
            phaseN = ackThis ? pend : PH_IGNORE;
            st.loadCount = ackThis && (pend == PH_RCOUNT);
          end else if (!sdaQ && !remainZero) begin
            st.loadNext = 1'b1;
            phaseN = PH_RDATA;
          end else begin
            phaseN = PH_IGNORE;
          end
        end
      end else if (sclFall) begin
        if (bitCnt == ACK_SLOT) begin
          st.setOe = rxPhase && ackThis;
          st.clrOe = !(rxPhase && ackThis);
        end else if (txPhase) begin
          st.txBit = 1'b1;
        end else begin
          st.clrOe = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      pend    <= PH_IDLE;
      bitCnt  <= '0;
      ackThis <= 1'b0;
    end else begin
      phase   <= phaseN;
      pend    <= pendN;
      bitCnt  <= bitN;
      ackThis <= ackN;
    end
  end
endmodule

// File: rtl/smb_datapath.sv
module smb_datapath import smb_regs_pkg::*; #(
  parameter int          NUM_REGS = 9,
  parameter int          CNT_IDX  = 8,
  parameter logic [7:0]  CNT_RST  = 8'h08
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    st,
  input  logic                       sdaQ,
  output logic [BYTE_W-1:0]          rxByte,
  output logic                       remainZero,
  output logic                       sdaOe,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] index;
  logic [BYTE_W-1:0] remain;
  logic [BYTE_W-1:0] txByte;
  logic [BYTE_W-1:0] readMux;
  logic [BYTE_W-1:0] regFile [NUM_REGS];

  assign rxByte     = {shiftReg[BYTE_W-2:0], sdaQ};
  assign remainZero = (remain == '0);

  // unimplemented indices read as zero
  always_comb begin
    readMux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (index == BYTE_W'(i)) readMux = regFile[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      index    <= '0;
      remain   <= '0;
      txByte   <= '0;
      sdaOe    <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++)
        regFile[i] <= (i == CNT_IDX) ? CNT_RST : '0;
    end else begin
      if (st.shiftIn)    shiftReg <= rxByte;
      if (st.loadIndex)  index    <= rxByte;
      if (st.loadRemain) remain   <= rxByte;
      if (st.writeReg) begin
        for (int i = 0; i < NUM_REGS; i++)
          if (index == BYTE_W'(i)) regFile[i] <= rxByte;
        index  <= index + 1'b1;
        remain <= remain - 1'b1;
      end
      if (st.loadCount) begin
        txByte <= regFile[CNT_IDX];
        remain <= regFile[CNT_IDX];
      end
      if (st.loadNext) begin
        txByte <= readMux;
        index  <= index + 1'b1;
        remain <= remain - 1'b1;
      end
      if (st.txBit) begin
        sdaOe  <= !txByte[BYTE_W-1];
        txByte <= {txByte[BYTE_W-2:0], 1'b0};
      end
      if (st.setOe) sdaOe <= 1'b1;
      if (st.clrOe) sdaOe <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regsOut[g*BYTE_W +: BYTE_W] = regFile[g];
  end
endmodule

// File: rtl/smb_block_regs.sv
module smb_block_regs import smb_regs_pkg::*; #(
  parameter int          NUM_REGS    = 9,
  parameter int          CNT_IDX     = 8,
  parameter logic [7:0]  CNT_RST     = 8'h08,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  logic sclQ, sdaQ, sclRise, sclFall, startSeen, stopSeen;
  logic [BYTE_W-1:0] rxByte;
  logic remainZero;
  strobe_t st;
  phase_t phase;
  logic [BIT_CNT_W-1:0] bitCnt;

  smb_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclQ(sclQ), .sdaQ(sdaQ), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  smb_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaQ(sdaQ),
    .rxByte(rxByte), .remainZero(remainZero),
    .st(st), .phase(phase), .bitCnt(bitCnt)
  );

  smb_datapath #(.NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .sdaQ(sdaQ),
    .rxByte(rxByte), .remainZero(remainZero),
    .sdaOe(sdaOe), .regsOut(regsOut)
  );

  logic unusedSclQ;
  assign unusedSclQ = sclQ;
endmodule

// File: rtl/smb_block_regs_chk.sv
module smb_block_regs_chk import smb_regs_pkg::*; #(
  parameter int NUM_REGS = 9
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sclIn,
  input logic                       sdaOe,
  input logic [NUM_REGS*BYTE_W-1:0] regsOut,
  input phase_t                     phase,
  input logic [BIT_CNT_W-1:0]       bitCnt,
  input logic                       sclRise,
  input logic                       sdaQ,
  input logic                       stopSeen
);
  a_r1_released_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !sdaOe);

  a_r2_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE) |-> !sdaOe);

  a_r3_regs_move_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regsOut) |-> ($past(phase) == PH_WDATA));

  a_r8_stop_returns_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (phase == PH_IDLE));

  a_r9_drive_moves_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  a_r10_nack_ends_read: assert property (@(posedge clk) disable iff (!rstN)
    (sclRise && bitCnt == BIT_CNT_W'(BYTE_W) && sdaQ &&
     (phase == PH_RCOUNT || phase == PH_RDATA)) |=> (phase == PH_IGNORE));
endmodule

bind smb_block_regs smb_block_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .regsOut(regsOut),
  .phase(phase), .bitCnt(bitCnt), .sclRise(sclRise), .sdaQ(sdaQ),
  .stopSeen(stopSeen)
);

// File: tb/smb_block_regs_bench.sv
module smb_block_regs_bench;
  localparam int NUM_REGS = 9;
  localparam int Q = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaHost = 1'b1;
  logic sdaOe;
  logic [NUM_REGS*8-1:0] regsOut;
  wire busSda = sdaHost & ~sdaOe;

  int checks = 0;
  int errors = 0;
  int highMoves = 0;
  logic prevOe = 1'b0;

  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] obsVal;
  event obsEv;

  always #5 clk = ~clk;

  smb_block_regs u_smb_block_regs (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(busSda),
    .sdaOe(sdaOe), .regsOut(regsOut)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int regAt(int i);
    return int'(regsOut[i*8 +: 8]);
  endfunction

  // scoreboard monitor
  initial forever begin
    @(obsEv);
    if (expQ.size() == 0) check("scoreboard underflow", 1, 0);
    else check(tagQ.pop_front(), int'(obsVal), int'(expQ.pop_front()));
  end

  // R9: drive may only move while the clock line is low
  always @(negedge clk) begin
    if (rstN && scl && (sdaOe !== prevOe)) highMoves++;
    prevOe <= sdaOe;
  end

  task automatic busStart();
    sdaHost = 1'b1; #Q; scl = 1'b1; #Q; sdaHost = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic busStop();
    sdaHost = 1'b0; #Q; scl = 1'b1; #Q; sdaHost = 1'b1; #Q;
  endtask

  task automatic putBit(logic b);
    sdaHost = b; #Q; scl = 1'b1; #Q; scl = 1'b0; #Q;
  endtask

  task automatic getBit(output logic b);
    sdaHost = 1'b1; #Q; scl = 1'b1; #(Q/2); b = busSda; #(Q/2); scl = 1'b0; #Q;
  endtask

  task automatic sendByte(logic [7:0] v, logic expAck, string tag);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    expQ.push_back({7'd0, expAck});
    tagQ.push_back(tag);
    getBit(b);
    obsVal = {7'd0, !b};
    ->obsEv;
  endtask

  task automatic recvByte(logic [7:0] expV, logic hostAck, string tag);
    logic b;
    logic [7:0] v;
    expQ.push_back(expV);
    tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    obsVal = v;
    ->obsEv;
    putBit(!hostAck);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23 rstN = 1'b1;
    @(negedge clk);
    #100;
    // R1 reset state
    for (int i = 0; i < NUM_REGS; i++)
      check("R1 reset register", regAt(i), (i == 8) ? 8'h08 : 8'h00);
    check("R1 line released", int'(sdaOe), 0);

    // R3 write three bytes at index 2
    busStart();
    sendByte(8'hD2, 1'b1, "R2 write address ack");
    sendByte(8'h02, 1'b1, "R3 index ack");
    sendByte(8'h03, 1'b1, "R3 count ack");
    sendByte(8'hA1, 1'b1, "R3 data ack");
    sendByte(8'hB2, 1'b1, "R3 data ack");
    sendByte(8'hC3, 1'b1, "R3 data ack");
    busStop();
    check("R3 reg2", regAt(2), 8'hA1);
    check("R3 reg3", regAt(3), 8'hB2);
    check("R3 reg4", regAt(4), 8'hC3);

    // R5 program the read length
    busStart();
    sendByte(8'hD2, 1'b1, "R2 write address ack");
    sendByte(8'h08, 1'b1, "R5 index ack");
    sendByte(8'h01, 1'b1, "R5 count ack");
    sendByte(8'h03, 1'b1, "R5 length write ack");
    busStop();
    check("R5 length register", regAt(8), 8'h03);

    // R4 read back from index 2
    busStart();
    sendByte(8'hD2, 1'b1, "R4 write address ack");
    sendByte(8'h02, 1'b1, "R4 index ack");
    busStart();
    sendByte(8'hD3, 1'b1, "R2 read address ack");
    recvByte(8'h03, 1'b1, "R5 length byte");
    recvByte(8'hA1, 1'b1, "R4 data byte 0");
    recvByte(8'hB2, 1'b1, "R4 data byte 1");
    recvByte(8'hC3, 1'b0, "R4 data byte 2");
    busStop();

    // R10 early not-acknowledge releases the line
    busStart();
    sendByte(8'hD2, 1'b1, "R10 write address ack");
    sendByte(8'h02, 1'b1, "R10 index ack");
    busStart();
    sendByte(8'hD3, 1'b1, "R10 read address ack");
    recvByte(8'h03, 1'b1, "R10 length byte");
    recvByte(8'hA1, 1'b0, "R10 data byte");
    recvByte(8'hFF, 1'b0, "R10 line released after nack");
    busStop();

    // R2 foreign address ignored
    busStart();
    sendByte(8'hA0, 1'b0, "R2 foreign address nack");
    sendByte(8'h00, 1'b0, "R2 ignored byte");
    sendByte(8'h01, 1'b0, "R2 ignored byte");
    sendByte(8'h55, 1'b0, "R2 ignored byte");
    busStop();
    check("R2 reg0 untouched", regAt(0), 8'h00);

    // R7 bytes beyond the count
    busStart();
    sendByte(8'hD2, 1'b1, "R7 address ack");
    sendByte(8'h00, 1'b1, "R7 index ack");
    sendByte(8'h01, 1'b1, "R7 count ack");
    sendByte(8'h5A, 1'b1, "R7 counted byte ack");
    sendByte(8'h77, 1'b0, "R7 extra byte nack");
    busStop();
    check("R7 reg0", regAt(0), 8'h5A);
    check("R7 reg1 untouched", regAt(1), 8'h00);

    // R6 out-of-range write and read
    busStart();
    sendByte(8'hD2, 1'b1, "R6 address ack");
    sendByte(8'h08, 1'b1, "R6 index ack");
    sendByte(8'h02, 1'b1, "R6 count ack");
    sendByte(8'h02, 1'b1, "R6 in-range byte ack");
    sendByte(8'h99, 1'b1, "R6 out-of-range byte ack");
    busStop();
    check("R6 reg8", regAt(8), 8'h02);
    check("R6 reg0 not aliased", regAt(0), 8'h5A);
    busStart();
    sendByte(8'hD2, 1'b1, "R6 address ack");
    sendByte(8'h08, 1'b1, "R6 index ack");
    busStart();
    sendByte(8'hD3, 1'b1, "R6 read address ack");
    recvByte(8'h02, 1'b1, "R5 new length byte");
    recvByte(8'h02, 1'b1, "R6 reg8 read");
    recvByte(8'h00, 1'b0, "R6 out-of-range read zero");
    busStop();

    // R8 STOP in the middle of a byte
    busStart();
    sendByte(8'hD2, 1'b1, "R8 address ack");
    sendByte(8'h05, 1'b1, "R8 index ack");
    sendByte(8'h02, 1'b1, "R8 count ack");
    sendByte(8'h3C, 1'b1, "R8 data ack");
    putBit(1'b1); putBit(1'b0); putBit(1'b1);
    busStop();
    check("R8 reg5 kept", regAt(5), 8'h3C);
    check("R8 reg6 not written", regAt(6), 8'h00);
    busStart();
    sendByte(8'hD2, 1'b1, "R8 address ack after abort");
    sendByte(8'h06, 1'b1, "R8 index ack");
    sendByte(8'h01, 1'b1, "R8 count ack");
    sendByte(8'h44, 1'b1, "R8 data ack");
    busStop();
    check("R8 reg6 after abort", regAt(6), 8'h44);

    // R8 repeated START in the middle of a byte
    busStart();
    sendByte(8'hD2, 1'b1, "R8 address ack");
    putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busStart();
    sendByte(8'hD2, 1'b1, "R8 address ack after restart");
    sendByte(8'h01, 1'b1, "R8 index ack");
    sendByte(8'h01, 1'b1, "R8 count ack");
    sendByte(8'h66, 1'b1, "R8 data ack");
    busStop();
    check("R8 reg1 after restart", regAt(1), 8'h66);
    check("R3 reg3 kept", regAt(3), 8'hB2);

    #Q;
    check("R9 drive moved while clock high", highMoves, 0);
    check("scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule